// File: doc/BRIEF.md
# Audio Serial Clock Ratio Generator

This block produces the timing of an audio serial port that runs as clock master. Its only time base is the master clock. It divides that clock into bit-clock edge strobes and a frame (sample-rate) clock level. The divide ratios come from three selects taken together. The speed mode picks the family of master-clock-to-frame ratios. The ratio select picks one ratio inside that family. The format select fixes how many bit periods make up one frame.

The selects are captured only while the synchronous reset is high. A new setting therefore always starts from bit zero of a fresh frame and never produces a partial frame. Some combinations cannot be produced. These are the multi-slot format, the one-line formats at quad speed, the one-line formats in double speed below a ratio of 256, reserved codes, and any setting whose bit divider is not a whole number. For such a setting the block raises a configuration-error flag and holds every clock output low. The bit clock is given as two master-clock-cycle strobes, one marking its falling edge and one marking its rising edge. When the bit clock equals the master clock, both strobes are high on every cycle.

Top module: `audclk_ratio_gen`

## Requirements
- R1: With a legal setting, `bclk_fall` is high for one cycle every D master-clock cycles, where D = master-clock-to-frame ratio / bits per frame. It is high in the first cycle after `rst` falls.
- R2: Bits per frame are 64 for `fmt_sel`=0 (two-channel standard, left- or right-justified), 128 for `fmt_sel`=1 (one-line, first variant) and 256 for `fmt_sel`=2 (one-line, second variant). `fclk` is low for the first half of those bit periods in each frame and high for the second half. It changes only in cycles where `bclk_fall` is high.
- R3: `bclk_rise` is high once per bit period, floor(D/2) cycles after `bclk_fall`. When D=1, both strobes are high on every cycle.
- R4: `fmt_sel`=3 (multi-slot format) is illegal in master operation. It sets `cfg_err`=1 and holds `bclk_fall`, `bclk_rise`, `fclk` and `frame_start` at 0.
- R5: Either one-line format with quad speed (`speed_sel`=2) is illegal and sets `cfg_err`.
- R6: `speed_sel` 0/1/2 selects single/double/quad speed. `ratio_sel` 0..4 selects the base ratios 256, 384, 512, 768 and 1024, shifted right by `speed_sel`. `speed_sel`=3 or `ratio_sel` 5..7 sets `cfg_err`.
- R7: Either one-line format at double speed with a ratio below 256 is illegal and sets `cfg_err`.
- R8: A setting whose ratio is not a whole multiple of the bits per frame (for example 384 with 256 bits) sets `cfg_err`.
- R9: The selects are captured on clock edges where `rst` is high. Changing them while `rst` is low has no effect on any output, including `cfg_err`.
- R10: While `rst` is high, all four clock outputs are 0.
- R11: `frame_start` is high in the `bclk_fall` cycle of bit 0 of every frame, once every D × bits cycles, and `fclk` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every output is timed from it |
| rst | input | 1 | Synchronous active-high reset; captures the selects |
| speed_sel | input | 2 | Speed mode: 0 single, 1 double, 2 quad, 3 reserved |
| ratio_sel | input | 3 | Ratio index within the speed family, 0..4 valid |
| fmt_sel | input | 2 | Format: 0 standard 64-bit, 1 one-line 128-bit, 2 one-line 256-bit, 3 multi-slot |
| bclk_fall | output | 1 | Strobe: the bit clock falls in this cycle |
| bclk_rise | output | 1 | Strobe: the bit clock rises in this cycle |
| fclk | output | 1 | Frame clock level, 50 percent duty |
| frame_start | output | 1 | Strobe: first bit of a frame begins |
| cfg_err | output | 1 | Captured setting is not allowed; clocks idle |

## Verification
The embedded properties check several rules on every cycle. Outputs stay silent under an error or a reset. The bit and frame counters stay inside their divider ranges. `fclk` moves only on a falling-edge strobe, and a frame starts only with `fclk` low. The two strobes coincide only when the divider is one. Every accepted setting divides exactly. The captured setting never moves while running. The exact spacing of the strobes and the frame length for each select combination can only be shown by the directed scenarios. The same holds for which combinations are rejected and for the selects being ignored outside reset. The bench compares these cycle by cycle against its own arithmetic model.

// File: rtl/audclk_pkg.sv
`timescale 1ns/1ps
package audclk_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_RSVD   = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LINE1 = 2'd1,
    FMT_LINE2 = 2'd2,
    FMT_SLOTS = 2'd3
  } fmt_e;

  // Master-clock-to-frame ratio for a speed family and ratio index.
  function automatic int unsigned mclk_ratio(input logic [1:0] spd,
                                             input logic [2:0] sel,
                                             input int unsigned base);
    int unsigned r;
    case (sel)
      3'd0:    r = base;
      3'd1:    r = (base * 3) / 2;
      3'd2:    r = base * 2;
      3'd3:    r = base * 3;
      3'd4:    r = base * 4;
      default: r = 0;
    endcase
    return r >> spd;
  endfunction

  // Bit periods per frame for a format.
  function automatic int unsigned frame_bits(input logic [1:0] fmt,
                                             input int unsigned std_bits);
    int unsigned b;
    case (fmt)
      FMT_STD:   b = std_bits;
      FMT_LINE1: b = std_bits * 2;
      FMT_LINE2: b = std_bits * 4;
      default:   b = 0;
    endcase
    return b;
  endfunction

  // Any reason the combination cannot be generated as master.
  function automatic logic cfg_illegal(input logic [1:0] spd,
                                       input logic [2:0] sel,
                                       input logic [1:0] fmt,
                                       input int unsigned ratio,
                                       input int unsigned bits,
                                       input int unsigned base);
    logic one_line;
    logic bad;
    one_line = (fmt == FMT_LINE1) || (fmt == FMT_LINE2);
    bad = 1'b0;
    if (spd == SPD_RSVD) bad = 1'b1;
    if (sel > 3'd4) bad = 1'b1;
    if (fmt == FMT_SLOTS) bad = 1'b1;
    if (one_line && (spd == SPD_QUAD)) bad = 1'b1;
    if (one_line && (spd == SPD_DOUBLE) && (ratio < base)) bad = 1'b1;
    if ((bits == 0) || (ratio < bits) || ((ratio % bits) != 0)) bad = 1'b1;
    return bad;
  endfunction

endpackage

// File: rtl/audclk_cfg_latch.sv
`timescale 1ns/1ps
module audclk_cfg_latch
  import audclk_pkg::*;
#(
  parameter int unsigned BASE_RATIO = 256,
  parameter int unsigned STD_BITS   = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                speed_sel,
  input  logic [2:0]                ratio_sel,
  input  logic [1:0]                fmt_sel,
  output logic [$clog2(4*BASE_RATIO/STD_BITS):0] div_o,
  output logic [$clog2(4*STD_BITS):0]            bits_o,
  output logic                      err_o
);
  localparam int unsigned DIV_W  = $clog2(4*BASE_RATIO/STD_BITS) + 1;
  localparam int unsigned BITS_W = $clog2(4*STD_BITS) + 1;

  logic [1:0]  spd_q;
  logic [2:0]  sel_q;
  logic [1:0]  fmt_q;
  logic        seen_run;
  int unsigned ratio_w;
  int unsigned bits_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      spd_q    <= speed_sel;
      sel_q    <= ratio_sel;
      fmt_q    <= fmt_sel;
      seen_run <= 1'b0;
    end else begin
      seen_run <= 1'b1;
    end
  end

  always_comb begin
    ratio_w = mclk_ratio(spd_q, sel_q, BASE_RATIO);
    bits_w  = frame_bits(fmt_q, STD_BITS);
    err_o   = cfg_illegal(spd_q, sel_q, fmt_q, ratio_w, bits_w, BASE_RATIO);
    bits_o  = BITS_W'(bits_w);
    div_o   = (bits_w == 0) ? '0 : DIV_W'(ratio_w / bits_w);
  end

  // R8: an accepted setting divides the frame exactly
  p_exact_div_r8: assert property (@(posedge clk) disable iff (rst)
    !err_o |-> ((int'(div_o) * int'(bits_o)) == int'(ratio_w)));

  // R9: the captured setting never moves while running
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    seen_run |-> ($stable(spd_q) && $stable(sel_q) && $stable(fmt_q) && $stable(err_o)));

  // R5: one-line formats are never accepted at quad speed
  p_line_quad_r5: assert property (@(posedge clk) disable iff (rst)
    ((fmt_q == FMT_LINE1 || fmt_q == FMT_LINE2) && spd_q == SPD_QUAD) |-> err_o);

endmodule

// File: rtl/audclk_bit_div.sv
`timescale 1ns/1ps
module audclk_bit_div #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bclk_fall,
  output logic             bclk_rise,
  output logic             bit_wrap
);
  logic [DIV_W-1:0] mcnt;
  logic [DIV_W-1:0] rise_pt;

  assign rise_pt   = div >> 1;
  assign bit_wrap  = run && (mcnt == (div - DIV_W'(1)));
  assign bclk_fall = run && (mcnt == '0);
  assign bclk_rise = run && (mcnt == rise_pt);

  always_ff @(posedge clk) begin
    if (rst || !run)   mcnt <= '0;
    else if (bit_wrap) mcnt <= '0;
    else               mcnt <= mcnt + DIV_W'(1);
  end

  // R1: phase counter stays inside one bit period
  p_mcnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    run |-> (mcnt < div));

  // R3: both edge strobes in one cycle only for a divide-by-one bit clock
  p_dual_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (bclk_fall && bclk_rise) |-> (div == DIV_W'(1)));

endmodule

// File: rtl/audclk_frame_div.sv
`timescale 1ns/1ps
module audclk_frame_div #(
  parameter int unsigned BITS_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              bit_wrap,
  input  logic              bclk_fall,
  input  logic [BITS_W-1:0] bits,
  output logic              fclk,
  output logic              frame_start
);
  logic [BITS_W-1:0] bcnt;
  logic              frame_end;

  assign frame_end   = (bcnt == (bits - BITS_W'(1)));
  assign fclk        = run && (bcnt >= (bits >> 1));
  assign frame_start = bclk_fall && (bcnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)   bcnt <= '0;
    else if (bit_wrap) bcnt <= frame_end ? '0 : bcnt + BITS_W'(1);
  end

  // R2: bit index stays inside one frame
  p_bcnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (bcnt < bits));

  // R2: the frame clock moves only with a bit-clock falling edge
  p_fclk_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(fclk) |-> bclk_fall);

  // R11: a frame begins in the low half of the frame clock
  p_start_low_r11: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !fclk);

endmodule

// File: rtl/audclk_ratio_gen.sv
`timescale 1ns/1ps
module audclk_ratio_gen
  import audclk_pkg::*;
#(
  parameter int unsigned BASE_RATIO = 256,
  parameter int unsigned STD_BITS   = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] speed_sel,
  input  logic [2:0] ratio_sel,
  input  logic [1:0] fmt_sel,
  output logic       bclk_fall,
  output logic       bclk_rise,
  output logic       fclk,
  output logic       frame_start,
  output logic       cfg_err
);
  localparam int unsigned DIV_W  = $clog2(4*BASE_RATIO/STD_BITS) + 1;
  localparam int unsigned BITS_W = $clog2(4*STD_BITS) + 1;

  logic [DIV_W-1:0]  div_w;
  logic [BITS_W-1:0] bits_w;
  logic              run_w;
  logic              bit_wrap_w;

  audclk_cfg_latch #(
    .BASE_RATIO(BASE_RATIO),
    .STD_BITS  (STD_BITS)
  ) cfg_i (
    .clk      (clk),
    .rst      (rst),
    .speed_sel(speed_sel),
    .ratio_sel(ratio_sel),
    .fmt_sel  (fmt_sel),
    .div_o    (div_w),
    .bits_o   (bits_w),
    .err_o    (cfg_err)
  );

  assign run_w = !rst && !cfg_err;

  audclk_bit_div #(.DIV_W(DIV_W)) bdiv_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run_w),
    .div      (div_w),
    .bclk_fall(bclk_fall),
    .bclk_rise(bclk_rise),
    .bit_wrap (bit_wrap_w)
  );

  audclk_frame_div #(.BITS_W(BITS_W)) fdiv_i (
    .clk        (clk),
    .rst        (rst),
    .run        (run_w),
    .bit_wrap   (bit_wrap_w),
    .bclk_fall  (bclk_fall),
    .bits       (bits_w),
    .fclk       (fclk),
    .frame_start(frame_start)
  );

  // R4: a rejected setting leaves every clock output silent
  p_idle_on_err_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !(bclk_fall || bclk_rise || fclk || frame_start));

  // R10: reset silences every clock output
  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |-> !(bclk_fall || bclk_rise || fclk || frame_start));

endmodule

// File: tb/audclk_ratio_gen_tb_top.sv
`timescale 1ns/1ps
module audclk_ratio_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] speed_sel = 2'd0;
  logic [2:0] ratio_sel = 3'd0;
  logic [1:0] fmt_sel = 2'd0;
  logic       bclk_fall, bclk_rise, fclk, frame_start, cfg_err;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  audclk_ratio_gen dut_i (
    .clk(clk), .rst(rst), .speed_sel(speed_sel), .ratio_sel(ratio_sel),
    .fmt_sel(fmt_sel), .bclk_fall(bclk_fall), .bclk_rise(bclk_rise),
    .fclk(fclk), .frame_start(frame_start), .cfg_err(cfg_err)
  );

  // Independent model: ratio in units of 64 master clocks per step.
  function automatic int m_ratio(int spd, int sel);
    int u;
    case (sel)
      0: u = 4; 1: u = 6; 2: u = 8; 3: u = 12; 4: u = 16; default: u = 0;
    endcase
    return (u * 64) / (1 << spd);
  endfunction

  function automatic int m_bits(int fmt);
    return (fmt < 3) ? (64 << fmt) : 0;
  endfunction

  function automatic int m_bad(int spd, int sel, int fmt);
    int r, b;
    if (spd == 3 || sel > 4 || fmt == 3) return 1;
    r = m_ratio(spd, sel);
    b = m_bits(fmt);
    if (fmt != 0 && spd == 2) return 1;
    if (fmt != 0 && spd == 1 && r < 256) return 1;
    if (r < b || (r % b) != 0) return 1;
    return 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Capture a setting under reset; R10 checked while reset is high.
  task automatic load_cfg(int spd, int sel, int fmt);
    @(negedge clk);
    speed_sel = 2'(spd); ratio_sel = 3'(sel); fmt_sel = 2'(fmt); rst = 1'b1;
    @(negedge clk); #1;
    check("R10", "outputs in reset", int'({bclk_fall, bclk_rise, fclk, frame_start}), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  // Legal setting: compare every output against the model for two frames.
  task automatic t_legal(string req, int spd, int sel, int fmt, bit disturb);
    int d, b, mism;
    load_cfg(spd, sel, fmt);
    check(req, "cfg_err legal", int'(cfg_err), m_bad(spd, sel, fmt));
    b = m_bits(fmt);
    d = m_ratio(spd, sel) / b;
    mism = 0;
    for (int t = 0; t < 2 * d * b + 8; t++) begin
      logic [3:0] exp_v;
      int bit_i;
      bit_i = (t / d) % b;
      exp_v = {(t % d) == 0, (t % d) == (d / 2), bit_i >= (b / 2), (t % (d * b)) == 0};
      if ({bclk_fall, bclk_rise, fclk, frame_start} !== exp_v) begin
        if (mism == 0)
          $display("FAIL %s waveform cycle %0d: actual %b expected %b", req, t,
                   {bclk_fall, bclk_rise, fclk, frame_start}, exp_v);
        mism++;
      end
      if (disturb && t == 5) begin
        speed_sel = 2'd3; ratio_sel = 3'd7; fmt_sel = 2'd3;
      end
      @(negedge clk); #1;
    end
    n_tests++;
    if (mism != 0) n_fail++;
    if (disturb) check("R9", "cfg_err after select change", int'(cfg_err), 0);
  endtask

  // Illegal setting: flag raised, clocks stay idle.
  task automatic t_illegal(string req, int spd, int sel, int fmt);
    int busy;
    load_cfg(spd, sel, fmt);
    check(req, "cfg_err illegal", int'(cfg_err), m_bad(spd, sel, fmt));
    busy = 0;
    for (int t = 0; t < 40; t++) begin
      if (bclk_fall || bclk_rise || fclk || frame_start) busy++;
      @(negedge clk); #1;
    end
    check({req, " R4"}, "active cycles while flagged", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R10", "reset state", int'({bclk_fall, bclk_rise, fclk, frame_start}), 0);
    t_legal("R1 R2 R3 R11 single 256 std", 0, 0, 0, 1'b0);
    t_legal("R1 R3 odd divider double 192", 1, 1, 0, 1'b0);
    t_legal("R3 R6 quad 64 divide by one", 2, 0, 0, 1'b0);
    t_legal("R2 R6 single 1024 line1", 0, 4, 1, 1'b0);
    t_legal("R2 R3 single 256 line2", 0, 0, 2, 1'b0);
    t_legal("R2 R7 double 512 line2", 1, 4, 2, 1'b0);
    t_illegal("R8", 0, 1, 2);
    t_illegal("R4", 0, 0, 3);
    t_illegal("R5", 2, 4, 1);
    t_illegal("R7", 1, 0, 1);
    t_illegal("R6 reserved speed", 3, 0, 0);
    t_illegal("R6 ratio index", 0, 5, 0);
    t_legal("R9 R1 selects ignored while running", 0, 2, 0, 1'b1);
    t_legal("R1 recovery quad 256", 2, 4, 0, 1'b0);
    done = 1'b1;
    finish_run();
  end

endmodule